// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between a memory controller's access arbiter and the SDRAM command pins. It decides when the device is put to sleep and when it is woken. A two-bit policy field selects the sleep state: none, self refresh, power-down or deep power-down. Around every access the sequencer issues the entry and exit commands, drives the clock-enable pin (CKE) and controls a gate on the memory clock. It grants a pending access only once the device is awake and has settled for a fixed number of cycles.

The sequencer also keeps the device's extended mode register current. After initialization, a change to the partial-array refresh selection schedules one register write. That write carries the newest selection together with the temperature-compensation field. A timing-select input places the write either just before self refresh is entered or directly after a refresh command that meets a waiting access. Deep power-down cannot be left through an access. The block raises a flag that calls for re-initialization, and only a reset clears it.

Top module: `lp_seq`

## Requirements
- R1: After reset, `cmd_o` is 0, `cke_o` and `mclk_en_o` are 1, and `grant_o` and `reinit_o` are 0. The command codes on `cmd_o` are: 0 no-op, 1 self refresh entry, 2 power-down entry, 3 deep power-down entry, 4 low-power exit, 5 extended mode register write, 6 refresh.
- R2: With policy 01 and the device idle and awake, the block issues code 1. In that same cycle it drives `cke_o` low and `mclk_en_o` low.
- R3: With policy 10 and the device idle and awake, the block issues code 2 and drives `cke_o` low. `mclk_en_o` is then the inverse of `clk_freeze_i`.
- R4: With policy 11 and the device idle, the block issues code 3 and drives `cke_o` low, with `mclk_en_o` following the inverse of `clk_freeze_i`. `reinit_o` then rises and stays high until reset, and no request is granted after that.
- R5: A request while the device is in self refresh or power-down produces code 4, with `cke_o` and `mclk_en_o` high. `grant_o` follows exactly EXIT_CYCLES cycles after that command.
- R6: When the device is awake and idle, a request is granted in the next cycle with a one-cycle `grant_o` pulse. The block then waits for `done_i`. Under policy 01 or 10 it re-enters low power one cycle after the access completes, unless a new request is waiting.
- R7: A policy change made while the device sleeps has no effect until an access wakes the device.
- R8: Once `init_done_i` is high, a change of `pasr_i` schedules one extended mode register write. Changes made before that schedule nothing, and a newer value replaces a pending one. When code 5 is issued, `emr_val_o` equals {`tcr_i`, selection}.
- R9: With `upd_sel_i` = 0, a pending register write is issued as code 5 in the cycle just before the code 1 that enters self refresh.
- R10: With `upd_sel_i` = 1, a pending write is issued in the cycle after a refresh command that met a waiting request. The grant follows one cycle later.
- R11: A refresh tick while the device is awake and idle issues code 6 and takes priority over a request. Ticks in any other state are ignored.
- R12: With policy 00, no sleep command is issued and `cke_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Device initialization finished |
| mode_i | input | 2 | Low-power policy field |
| clk_freeze_i | input | 1 | Stop memory clock in power-down and deep power-down |
| pasr_i | input | PASR_W | Partial-array refresh selection |
| tcr_i | input | TCR_W | Temperature-compensation field |
| upd_sel_i | input | 1 | Register-write timing: 0 before self refresh, 1 with refresh and request |
| req_i | input | 1 | Access request, held until granted |
| done_i | input | 1 | Granted access completed (one-cycle pulse) |
| ref_tick_i | input | 1 | Refresh due |
| cmd_o | output | 3 | Device command code |
| cke_o | output | 1 | Device clock-enable pin |
| mclk_en_o | output | 1 | Memory clock gate |
| grant_o | output | 1 | Access granted (one-cycle pulse) |
| reinit_o | output | 1 | Deep power-down entered; re-initialization needed |
| emr_val_o | output | PASR_W+TCR_W | Payload of the last extended mode register write |

## Verification
The bench builds the block with EXIT_CYCLES = 3 and the default 3-bit partial-array and 2-bit temperature fields. A wake latency of 3 differs from both the default and the minimum. An off-by-one in the exit timer, or a grant on the same edge as the exit command, therefore shows up as a cycle-exact mismatch. The 5-bit payload lets the bench spot a field swap or a stale selection in the register write. The bench also checks that a policy change made while asleep is deferred.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_SR   = 2'b01,
        MODE_PD   = 2'b10,
        MODE_DEEP = 2'b11
    } lp_mode_e;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_SR   = 3'd1,
        CMD_PD   = 3'd2,
        CMD_DPD  = 3'd3,
        CMD_EXIT = 3'd4,
        CMD_EMR  = 3'd5,
        CMD_REF  = 3'd6
    } dev_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_SLEEP,
        ST_WAKE,
        ST_EMR,
        ST_DEEP
    } seq_state_e;

    typedef struct packed {
        dev_cmd_e cmd;
        logic     cke;
        logic     mclk_en;
    } pin_set_t;

    localparam pin_set_t AWAKE_PINS = '{cmd: CMD_NOP, cke: 1'b1, mclk_en: 1'b1};

    // Pin pattern for entering the sleep state a policy selects.
    function automatic pin_set_t sleep_pins(lp_mode_e m, logic freeze);
        pin_set_t p;
        unique case (m)
            MODE_SR:   p = '{cmd: CMD_SR,  cke: 1'b0, mclk_en: 1'b0};
            MODE_PD:   p = '{cmd: CMD_PD,  cke: 1'b0, mclk_en: !freeze};
            MODE_DEEP: p = '{cmd: CMD_DPD, cke: 1'b0, mclk_en: !freeze};
            default:   p = AWAKE_PINS;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lp_emr_track.sv
module lp_emr_track #(
    parameter int PASR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done_i,
    input  logic [PASR_W-1:0] pasr_i,
    input  logic              issue_i,
    output logic              pend_o,
    output logic [PASR_W-1:0] pasr_o
);

    logic [PASR_W-1:0] shadow_q;
    logic              pend_q;
    logic              changed;

    assign changed = init_done_i && (pasr_i != shadow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (changed) begin
            // A fresh selection replaces any value still waiting.
            shadow_q <= pasr_i;
            pend_q   <= 1'b1;
        end else begin
            if (!init_done_i) shadow_q <= pasr_i;
            if (issue_i)      pend_q   <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign pasr_o = shadow_q;

endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
    parameter int EXIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic last_o
);

    localparam int CW = $clog2(EXIT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (start_i)      cnt_q <= CW'(EXIT_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/lp_seq.sv
module lp_seq
    import lp_seq_pkg::*;
#(
    parameter int EXIT_CYCLES = 2,
    parameter int PASR_W      = 3,
    parameter int TCR_W       = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    init_done_i,
    input  logic [1:0]              mode_i,
    input  logic                    clk_freeze_i,
    input  logic [PASR_W-1:0]       pasr_i,
    input  logic [TCR_W-1:0]        tcr_i,
    input  logic                    upd_sel_i,
    input  logic                    req_i,
    input  logic                    done_i,
    input  logic                    ref_tick_i,
    output logic [2:0]              cmd_o,
    output logic                    cke_o,
    output logic                    mclk_en_o,
    output logic                    grant_o,
    output logic                    reinit_o,
    output logic [PASR_W+TCR_W-1:0] emr_val_o
);

    localparam int EMR_W = PASR_W + TCR_W;

    seq_state_e        state_q, nxt_state;
    lp_mode_e          mode_q;
    pin_set_t          pins_q, nxt_pins;
    logic              grant_q, nxt_grant;
    logic              reinit_q, nxt_reinit;
    logic [EMR_W-1:0]  emr_q;
    logic              emr_issue, emr_pend, tmr_start, tmr_last;
    logic [PASR_W-1:0] pasr_shd;

    lp_emr_track #(.PASR_W(PASR_W)) u_emr (
        .clk        (clk),
        .rst        (rst),
        .init_done_i(init_done_i),
        .pasr_i     (pasr_i),
        .issue_i    (emr_issue),
        .pend_o     (emr_pend),
        .pasr_o     (pasr_shd)
    );

    lp_exit_timer #(.EXIT_CYCLES(EXIT_CYCLES)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start_i(tmr_start),
        .last_o (tmr_last)
    );

    always_comb begin
        nxt_state  = state_q;
        nxt_pins   = pins_q;
        nxt_pins.cmd = CMD_NOP;
        nxt_grant  = 1'b0;
        nxt_reinit = reinit_q;
        emr_issue  = 1'b0;
        tmr_start  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_q == MODE_DEEP) begin
                    nxt_pins   = sleep_pins(mode_q, clk_freeze_i);
                    nxt_reinit = 1'b1;
                    nxt_state  = ST_DEEP;
                end else if (ref_tick_i) begin
                    nxt_pins.cmd = CMD_REF;
                    if (upd_sel_i && emr_pend && req_i) nxt_state = ST_EMR;
                end else if (req_i) begin
                    nxt_grant = 1'b1;
                    nxt_state = ST_BUSY;
                end else if (mode_q == MODE_SR && emr_pend && !upd_sel_i) begin
                    nxt_pins.cmd = CMD_EMR;
                    emr_issue    = 1'b1;
                end else if (mode_q != MODE_OFF) begin
                    nxt_pins  = sleep_pins(mode_q, clk_freeze_i);
                    nxt_state = ST_SLEEP;
                end
            end
            ST_BUSY: begin
                if (done_i) nxt_state = ST_IDLE;
            end
            ST_SLEEP: begin
                if (req_i) begin
                    nxt_pins     = AWAKE_PINS;
                    nxt_pins.cmd = CMD_EXIT;
                    tmr_start    = 1'b1;
                    nxt_state    = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (tmr_last) begin
                    nxt_grant = 1'b1;
                    nxt_state = ST_BUSY;
                end
            end
            ST_EMR: begin
                nxt_pins.cmd = CMD_EMR;
                emr_issue    = 1'b1;
                nxt_state    = ST_IDLE;
            end
            ST_DEEP: begin
                nxt_state = ST_DEEP;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_OFF;
            pins_q   <= AWAKE_PINS;
            grant_q  <= 1'b0;
            reinit_q <= 1'b0;
            emr_q    <= '0;
        end else begin
            state_q  <= nxt_state;
            pins_q   <= nxt_pins;
            grant_q  <= nxt_grant;
            reinit_q <= nxt_reinit;
            // Policy is frozen while the device sleeps.
            if (state_q != ST_SLEEP && state_q != ST_DEEP) mode_q <= lp_mode_e'(mode_i);
            if (emr_issue) emr_q <= {tcr_i, pasr_shd};
        end
    end

    assign cmd_o     = pins_q.cmd;
    assign cke_o     = pins_q.cke;
    assign mclk_en_o = pins_q.mclk_en;
    assign grant_o   = grant_q;
    assign reinit_o  = reinit_q;
    assign emr_val_o = emr_q;

endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk
    import lp_seq_pkg::*;
#(
    parameter int EXIT_CYCLES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd_o,
    input logic       cke_o,
    input logic       mclk_en_o,
    input logic       grant_o,
    input logic       reinit_o
);

    logic in_wake;
    int   wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_wake  <= 1'b0;
            wait_cnt <= 0;
        end else if (cmd_o == CMD_EXIT) begin
            in_wake  <= 1'b1;
            wait_cnt <= 1;
        end else if (grant_o) begin
            in_wake  <= 1'b0;
            wait_cnt <= 0;
        end else if (in_wake) begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    // R2
    sr_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_SR) |-> (!cke_o && !mclk_en_o));

    // R3
    pd_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PD) |-> !cke_o);

    // R4
    dpd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_DPD) |-> (reinit_o && !cke_o));

    // R4
    reinit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reinit_o |=> (reinit_o && !cke_o && !grant_o));

    // R5
    exit_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o && in_wake) |-> (wait_cnt == EXIT_CYCLES));

    // R5
    cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_o) |-> (cmd_o == CMD_EXIT));

    // R6
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> !grant_o);

    // R6
    grant_awake_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> (cke_o && mclk_en_o));

    // R8
    emr_awake_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_EMR) |-> (cke_o && mclk_en_o));

endmodule

bind lp_seq lp_seq_chk #(.EXIT_CYCLES(EXIT_CYCLES)) u_lp_seq_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_o    (cmd_o),
    .cke_o    (cke_o),
    .mclk_en_o(mclk_en_o),
    .grant_o  (grant_o),
    .reinit_o (reinit_o)
);

// File: tb/lp_seq_tb.sv
`timescale 1ns/1ps
module lp_seq_tb;

    localparam int NEXIT = 3;
    localparam int PW = 3;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_done = 0, frz = 0, upd = 0, req = 0, done = 0, tick = 0;
    logic [1:0] mode = 0;
    logic [PW-1:0] pasr = 0;
    logic [TW-1:0] tcr = 0;
    logic [2:0] cmd_o;
    logic cke_o, mclk_en_o, grant_o, reinit_o;
    logic [PW+TW-1:0] emr_val_o;

    int n_cmp = 0, n_bad = 0;
    string cur = "R1";
    bit armed = 0;

    always #2.5 clk = ~clk;

    lp_seq #(.EXIT_CYCLES(NEXIT), .PASR_W(PW), .TCR_W(TW)) u_dut (
        .clk(clk), .rst(rst), .init_done_i(init_done), .mode_i(mode),
        .clk_freeze_i(frz), .pasr_i(pasr), .tcr_i(tcr), .upd_sel_i(upd),
        .req_i(req), .done_i(done), .ref_tick_i(tick),
        .cmd_o(cmd_o), .cke_o(cke_o), .mclk_en_o(mclk_en_o),
        .grant_o(grant_o), .reinit_o(reinit_o), .emr_val_o(emr_val_o)
    );

    // Behavioural reference: phase 0 awake idle, 1 access, 2 asleep,
    // 3 settling, 4 register write due, 5 deep sleep.
    int m_phase, m_left, m_cmd, m_mode, m_shadow, m_emr;
    bit m_cke, m_clk, m_gnt, m_reinit, m_pend;

    always @(posedge clk) begin
        int old_phase, old_mode;
        bit issue;
        if (rst) begin
            m_phase = 0; m_left = 0; m_cmd = 0; m_mode = 0; m_shadow = 0;
            m_emr = 0; m_cke = 1; m_clk = 1; m_gnt = 0; m_reinit = 0; m_pend = 0;
        end else begin
            old_phase = m_phase; old_mode = m_mode; issue = 0;
            m_cmd = 0; m_gnt = 0;
            if (old_phase == 0) begin
                if (old_mode == 3) begin
                    m_cmd = 3; m_cke = 0; m_clk = !frz; m_reinit = 1; m_phase = 5;
                end else if (tick) begin
                    m_cmd = 6;
                    if (upd && m_pend && req) m_phase = 4;
                end else if (req) begin
                    m_gnt = 1; m_phase = 1;
                end else if (old_mode == 1) begin
                    if (m_pend && !upd) begin m_cmd = 5; issue = 1; end
                    else begin m_cmd = 1; m_cke = 0; m_clk = 0; m_phase = 2; end
                end else if (old_mode == 2) begin
                    m_cmd = 2; m_cke = 0; m_clk = !frz; m_phase = 2;
                end
            end else if (old_phase == 1) begin
                if (done) m_phase = 0;
            end else if (old_phase == 2) begin
                if (req) begin m_cmd = 4; m_cke = 1; m_clk = 1; m_left = NEXIT; m_phase = 3; end
            end else if (old_phase == 3) begin
                m_left = m_left - 1;
                if (m_left == 0) begin m_gnt = 1; m_phase = 1; end
            end else if (old_phase == 4) begin
                m_cmd = 5; issue = 1; m_phase = 0;
            end
            if (old_phase != 2 && old_phase != 5) m_mode = mode;
            if (issue) m_emr = tcr * (1 << PW) + m_shadow;
            if (init_done && pasr != m_shadow) begin
                m_shadow = pasr; m_pend = 1;
            end else begin
                if (!init_done) m_shadow = pasr;
                if (issue) m_pend = 0;
            end
        end
    end

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst) begin
            check(cur, "cmd", cmd_o, m_cmd);
            check(cur, "cke", cke_o, m_cke);
            check(cur, "mclk_en", mclk_en_o, m_clk);
            check(cur, "grant", grant_o, m_gnt);
            check(cur, "reinit", reinit_o, m_reinit);
            check(cur, "emr_val", emr_val_o, m_emr);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cmd(input string rq, input int code, input int lim);
        bit seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (cmd_o == code) seen = 1;
        end
        check(rq, "command seen", seen, 1);
    endtask

    task automatic wait_any(input int lim, output int code);
        code = 0;
        for (int i = 0; i < lim && code == 0; i++) begin
            @(negedge clk);
            code = cmd_o;
        end
    endtask

    // Returns cycles from exit command to grant (-1 if no exit seen).
    task automatic do_access(output int wait_cyc);
        int t = 0, te = -1, tg = -1;
        req = 1;
        for (int i = 0; i < 40 && tg < 0; i++) begin
            @(negedge clk);
            t++;
            if (cmd_o == 4) te = t;
            if (grant_o) tg = t;
        end
        req = 0;
        check(cur, "grant reached", tg >= 0, 1);
        wait_cyc = (te < 0) ? -1 : tg - te;
        cyc(2);
        done = 1;
        cyc(1);
        done = 0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int w, c;
        cyc(3);
        rst = 0;
        armed = 1;
        // R1 reset state
        check("R1", "cmd", cmd_o, 0);
        check("R1", "cke", cke_o, 1);
        check("R1", "mclk_en", mclk_en_o, 1);
        check("R1", "grant", grant_o, 0);
        check("R1", "reinit", reinit_o, 0);

        cur = "R12";
        cyc(6);
        check("R12", "cke", cke_o, 1);
        do_access(w);
        cyc(3);
        check("R12", "cke", cke_o, 1);

        cur = "R6";
        req = 1;
        cyc(1);
        req = 0;
        check("R6", "grant next cycle", grant_o, 1);
        cyc(1);
        check("R6", "grant pulse", grant_o, 0);
        cyc(1);
        done = 1; cyc(1); done = 0;

        cur = "R2";
        mode = 1;
        wait_cmd("R2", 1, 6);
        check("R2", "cke", cke_o, 0);
        check("R2", "mclk_en", mclk_en_o, 0);

        cur = "R5";
        do_access(w);
        check("R5", "exit to grant cycles", w, NEXIT);
        cur = "R6";
        wait_cmd("R6", 1, 4);

        cur = "R7";
        mode = 2;
        cyc(4);
        check("R7", "still self refresh cke", cke_o, 0);
        check("R7", "still self refresh clk", mclk_en_o, 0);
        cur = "R3";
        do_access(w);
        wait_cmd("R3", 2, 6);
        check("R3", "cke", cke_o, 0);
        check("R3", "mclk_en unfrozen", mclk_en_o, 1);
        frz = 1;
        do_access(w);
        check("R5", "exit to grant from power-down", w, NEXIT);
        wait_cmd("R3", 2, 6);
        check("R3", "mclk_en frozen", mclk_en_o, 0);

        cur = "R7";
        mode = 0;
        cyc(5);
        check("R7", "sleep kept", cke_o, 0);
        do_access(w);
        cyc(4);
        check("R7", "stays awake cke", cke_o, 1);
        check("R7", "stays awake clk", mclk_en_o, 1);

        cur = "R8";
        pasr = 1;
        cyc(3);
        init_done = 1;
        cyc(2);
        mode = 1;
        wait_any(8, c);
        check("R8", "no write before init", c, 1);
        mode = 0;
        do_access(w);
        cyc(3);
        pasr = 2;
        cyc(1);
        pasr = 4; tcr = 2;
        cyc(3);
        check("R8", "no write while policy 00", cmd_o, 0);
        mode = 1;
        cur = "R9";
        wait_any(8, c);
        check("R9", "write first", c, 5);
        check("R8", "payload newest", emr_val_o, 20);
        cyc(1);
        check("R9", "self refresh next", cmd_o, 1);

        cur = "R10";
        mode = 0;
        do_access(w);
        cyc(3);
        upd = 1; pasr = 3;
        cyc(3);
        req = 1; tick = 1;
        cyc(1);
        tick = 0;
        check("R11", "refresh first", cmd_o, 6);
        cyc(1);
        check("R10", "write after refresh", cmd_o, 5);
        check("R10", "payload", emr_val_o, 19);
        cyc(1);
        check("R10", "grant after write", grant_o, 1);
        req = 0;
        cyc(2);
        done = 1; cyc(1); done = 0;

        cur = "R11";
        cyc(3);
        req = 1; tick = 1;
        cyc(1);
        tick = 0;
        check("R11", "refresh wins", cmd_o, 6);
        check("R11", "no grant yet", grant_o, 0);
        cyc(1);
        check("R11", "grant after refresh", grant_o, 1);
        req = 0;
        cyc(2);
        done = 1; cyc(1); done = 0;
        mode = 2;
        wait_cmd("R11", 2, 6);
        cyc(2);
        tick = 1;
        cyc(1);
        tick = 0;
        check("R11", "tick ignored asleep", cmd_o, 0);
        check("R11", "still asleep", cke_o, 0);
        cyc(2);

        cur = "R4";
        mode = 3;
        cyc(3);
        check("R7", "deep deferred", reinit_o, 0);
        do_access(w);
        wait_cmd("R4", 3, 6);
        check("R4", "cke", cke_o, 0);
        check("R4", "reinit", reinit_o, 1);
        check("R4", "clk frozen", mclk_en_o, 0);
        req = 1;
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            check("R4", "no grant", grant_o, 0);
        end
        req = 0;
        cyc(2);
        check("R4", "reinit held", reinit_o, 1);

        summary();
        $finish;
    end

endmodule